// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block is a sequential integer arithmetic unit for a processor pipeline. It computes multiplication and division, each signed or unsigned, over two W-bit operands (W is 32 by default). A single adder/subtractor and a single shift register serve both operations, and each iteration step resolves one bit. Multiplication uses shift-and-add. Division uses the restoring method: in each step the divisor is trial-subtracted from the partial remainder, and the result is kept only when it is not negative.

A caller pulses `start` together with an opcode and two operands, then waits while `busy` is high. The results go to two W-bit registers, `hi` and `lo`, which can be read at any time. After a multiply, the pair holds the full 2W-bit product. After a divide, `hi` holds the remainder and `lo` holds the quotient. The unit never traps. A zero divisor is reported on `div_by_zero`, and the result registers then take defined values.

The opcode encoding is as follows. Bit 1 selects divide when it is 1 and multiply when it is 0. Bit 0 selects signed (two's complement) operands when it is 1 and unsigned operands when it is 0.

Top module: `md_unit`

## Requirements
- R1: With op = 2'b00 (unsigned multiply), once the operation completes, {hi, lo} equals the 2W-bit unsigned product of opnd_a and opnd_b.
- R2: With op = 2'b01 (signed multiply), once the operation completes, {hi, lo} equals the 2W-bit two's complement product of the two signed operands.
- R3: With op = 2'b10 (unsigned divide) and a nonzero divisor opnd_b, lo holds the quotient opnd_a / opnd_b and hi holds the remainder.
- R4: With op = 2'b11 (signed divide) and a nonzero divisor, the quotient is truncated toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend. Both values wrap to W bits, so the most negative dividend divided by -1 gives the most negative quotient and a zero remainder.
- R5: A divide with opnd_b = 0 sets div_by_zero to 1, sets lo to all ones and sets hi to opnd_a. Every other operation leaves div_by_zero at 0 when it completes.
- R6: A start pulse accepted while the unit is idle raises busy on the next cycle. busy then stays high for exactly W+2 cycles: one setup cycle, W iteration cycles and one sign-correction cycle. hi and lo carry the new result in the first cycle after busy falls.
- R7: A start pulse that arrives while busy is high is ignored. The current result comes from the operands that were accepted, and no second operation follows.
- R8: While reset is asserted, and after it is released, busy, hi, lo and div_by_zero are all 0.
- R9: hi and lo change only when an operation completes. Between operations they hold their value while op, opnd_a and opnd_b change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins an operation when the unit is idle |
| op | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| opnd_a | input | W | Multiplicand or dividend |
| opnd_b | input | W | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| hi | output | W | Product upper half, or remainder |
| lo | output | W | Product lower half, or quotient |
| div_by_zero | output | 1 | The last completed divide had a zero divisor |

## Verification
The bench builds the unit with W = 4. At that width every pairing of operands for all four opcodes can be run exhaustively: 1024 operations, each compared against a product, quotient and remainder computed arithmetically with integers. The sweep therefore covers every sign combination, the most negative operand in both multiply and divide, the wrapping case of the most negative value divided by -1, and a zero divisor with every dividend. Further directed runs check the busy window length, a start pulse during busy, and whether the results hold while the inputs change.

// File: rtl/md_pkg.sv
package md_pkg;
  // op[1] selects divide, op[0] selects signed operands
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SETUP = 2'b01,
    ST_ITER  = 2'b10,
    ST_FIX   = 2'b11
  } md_state_e;
endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic st_setup,
  output logic st_iter,
  output logic st_fix
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int LW = $clog2(W + 3) + 1;

  md_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            last_step;

  assign last_step = (cnt_q == CW'(W - 1));
  assign accept    = start && (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign st_setup  = (state_q == ST_SETUP);
  assign st_iter   = (state_q == ST_ITER);
  assign st_fix    = (state_q == ST_FIX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = ST_ITER;
        cnt_d   = '0;
      end
      ST_ITER: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) state_d = ST_FIX;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Checker: length of each busy window
  logic [LW-1:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len_q <= '0;
    else if (busy) run_len_q <= run_len_q + 1'b1;
    else           run_len_q <= '0;
  end

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len_q == LW'(W + 2)));

  p_setup_to_iter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_setup |=> st_iter);
endmodule

// File: rtl/md_step.sv
module md_step #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] sreg,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] acc_d,
  output logic [W-1:0] sreg_d
);
  localparam int AW = W + 2;

  logic [W:0]    shifted;
  logic [AW-1:0] opa, opb, sum;
  logic [W:0]    mul_res;
  logic          fits;

  assign shifted = {acc, sreg[W-1]};

  // Single shared adder/subtractor: add for multiply, subtract for divide
  always_comb begin
    opa = is_div ? {1'b0, shifted} : {2'b00, acc};
    opb = {2'b00, mcand} ^ {AW{is_div}};
    sum = opa + opb + AW'(is_div);
  end

  assign fits    = !sum[AW-1];
  assign mul_res = sreg[0] ? sum[W:0] : {1'b0, acc};

  always_comb begin
    if (is_div) begin
      acc_d  = fits ? sum[W-1:0] : shifted[W-1:0];
      sreg_d = {sreg[W-2:0], fits};
    end else begin
      {acc_d, sreg_d} = {mul_res, sreg[W-1:1]};
    end
  end
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         div_by_zero
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic accept, st_setup, st_iter, st_fix;

  md_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .accept   (accept),
    .busy     (busy),
    .st_setup (st_setup),
    .st_iter  (st_iter),
    .st_fix   (st_fix)
  );

  md_op_e       op_q, op_d;
  logic [W-1:0] a_q, a_d, b_q, b_d;
  logic [W-1:0] acc_q, acc_d, sreg_q, sreg_d, mcand_q, mcand_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         dz_q, dz_d;
  logic [W-1:0] step_acc, step_sreg;

  logic           is_div, a_neg, b_neg, flip, zero_div;
  logic [W-1:0]   abs_a, abs_b, quot_fix, rem_fix;
  logic [2*W-1:0] prod, prod_fix;

  assign is_div   = op_q[1];
  assign a_neg    = op_q[0] && a_q[W-1];
  assign b_neg    = op_q[0] && b_q[W-1];
  assign flip     = a_neg ^ b_neg;
  assign zero_div = is_div && (b_q == '0);
  assign abs_a    = a_neg ? (~a_q + 1'b1) : a_q;
  assign abs_b    = b_neg ? (~b_q + 1'b1) : b_q;

  md_step #(.W(W)) u_step (
    .is_div (is_div),
    .acc    (acc_q),
    .sreg   (sreg_q),
    .mcand  (mcand_q),
    .acc_d  (step_acc),
    .sreg_d (step_sreg)
  );

  // Sign correction of the magnitude result
  always_comb begin
    prod     = {acc_q, sreg_q};
    prod_fix = flip  ? (~prod + 1'b1)   : prod;
    quot_fix = flip  ? (~sreg_q + 1'b1) : sreg_q;
    rem_fix  = a_neg ? (~acc_q + 1'b1)  : acc_q;
  end

  // Next-state logic
  always_comb begin
    op_d    = op_q;
    a_d     = a_q;
    b_d     = b_q;
    acc_d   = acc_q;
    sreg_d  = sreg_q;
    mcand_d = mcand_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    dz_d    = dz_q;
    if (accept) begin
      op_d = md_op_e'(op);
      a_d  = opnd_a;
      b_d  = opnd_b;
    end
    if (st_setup) begin
      acc_d   = '0;
      sreg_d  = abs_a;
      mcand_d = abs_b;
    end
    if (st_iter) begin
      acc_d  = step_acc;
      sreg_d = step_sreg;
    end
    if (st_fix) begin
      dz_d = zero_div;
      if (!is_div) begin
        hi_d = prod_fix[2*W-1:W];
        lo_d = prod_fix[W-1:0];
      end else if (zero_div) begin
        hi_d = a_q;
        lo_d = '1;
      end else begin
        hi_d = rem_fix;
        lo_d = quot_fix;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q    <= OP_MULU;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      sreg_q  <= '0;
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      dz_q    <= 1'b0;
    end else begin
      op_q    <= op_d;
      a_q     <= a_d;
      b_q     <= b_d;
      acc_q   <= acc_d;
      sreg_q  <= sreg_d;
      mcand_q <= mcand_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      dz_q    <= dz_d;
    end
  end

  assign hi          = hi_q;
  assign lo          = lo_q;
  assign div_by_zero = dz_q;

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> ($stable(op_q) && $stable(a_q) && $stable(b_q)));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !st_fix |=> ($stable(hi_q) && $stable(lo_q)));

  p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_fix && zero_div) |=> (div_by_zero && (lo == '1) && (hi == $past(a_q))));

  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_iter && is_div && (mcand_q != '0)) |=> (acc_q < mcand_q));
endmodule

// File: tb/tb_md_unit.sv
`timescale 1ns/1ps
module tb_md_unit;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] opnd_a, opnd_b;
  logic         busy;
  logic [W-1:0] hi, lo;
  logic         div_by_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  md_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy),
    .hi(hi), .lo(lo), .div_by_zero(div_by_zero)
  );

  function automatic int sx(int v);
    return (v >= (1 << (W - 1))) ? v - (1 << W) : v;
  endfunction

  function automatic logic [2*W:0] model(int o, int a, int b);
    int p, q, r, hv, lv, dz;
    dz = 0;
    if (o < 2) begin
      p  = (o == 1) ? sx(a) * sx(b) : a * b;
      hv = (p >>> W) & M;
      lv = p & M;
    end else if (b == 0) begin
      dz = 1; hv = a; lv = M;
    end else begin
      q  = (o == 3) ? sx(a) / sx(b) : a / b;
      r  = (o == 3) ? sx(a) % sx(b) : a % b;
      hv = r & M;
      lv = q & M;
    end
    return {dz[0], hv[W-1:0], lv[W-1:0]};
  endfunction

  task automatic check(string tag, logic [2*W:0] act, logic [2*W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Launch an operation, optionally inject a second start while busy, return busy length
  task automatic run_op(int o, int a, int b, bit poke, output int blen);
    @(negedge clk);
    op = o[1:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    blen = 0;
    while (busy && blen < 100) begin
      blen++;
      if (poke && blen == 2) begin
        start = 1'b1; op = ~o[1:0]; opnd_a = ~a[W-1:0]; opnd_b = 1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int blen;
    logic [2*W:0] held;
    rst_n = 1'b0; start = 1'b0; op = 2'b00; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R8 in reset", {busy, div_by_zero, hi, lo}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 after reset", {busy, div_by_zero, hi, lo}, '0);

    // R6: busy window length, one per opcode
    for (int o = 0; o < 4; o++) begin
      run_op(o, 13, 3, 1'b0, blen);
      check("R6 busy length", blen, W + 2);
      check("R6 result at busy fall", {div_by_zero, hi, lo}, model(o, 13, 3));
    end

    // Exhaustive sweep: R1 R2 R3 R4 R5
    for (int o = 0; o < 4; o++) begin
      for (int a = 0; a <= M; a++) begin
        for (int b = 0; b <= M; b++) begin
          string tag;
          run_op(o, a, b, 1'b0, blen);
          case (o)
            0: tag = "R1 unsigned multiply";
            1: tag = "R2 signed multiply";
            2: tag = (b == 0) ? "R5 divide by zero" : "R3 unsigned divide";
            default: tag = (b == 0) ? "R5 divide by zero" : "R4 signed divide";
          endcase
          check(tag, {div_by_zero, hi, lo}, model(o, a, b));
        end
      end
    end

    // R4 corner: most negative / -1
    run_op(3, 1 << (W - 1), M, 1'b0, blen);
    check("R4 min over minus one", {div_by_zero, hi, lo}, {1'b0, W'(0), W'(1 << (W - 1))});

    // R5: zero divide then multiply clears the flag
    run_op(2, 9, 0, 1'b0, blen);
    check("R5 flag set", {div_by_zero, hi, lo}, {1'b1, W'(9), W'(M)});
    run_op(0, 2, 3, 1'b0, blen);
    check("R5 flag cleared", {div_by_zero, hi, lo}, {1'b0, W'(0), W'(6)});

    // R7: start during busy is ignored
    run_op(3, 11, 3, 1'b1, blen);
    check("R7 busy length unchanged", blen, W + 2);
    check("R7 first operands kept", {div_by_zero, hi, lo}, model(3, 11, 3));
    repeat (3) begin
      @(negedge clk);
      check("R7 no second run", busy, 1'b0);
    end

    // R9: results hold while inputs wander without start
    held = {div_by_zero, hi, lo};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      op = k[1:0]; opnd_a = W'(k * 5); opnd_b = W'(k + 1);
      @(negedge clk);
      check("R9 result held", {div_by_zero, hi, lo}, held);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule